// File: doc/BRIEF.md
# Segment Record Write Engine

This block writes a stream of payload data words into mass memory, one address segment at a time. Memory is split into fixed segments of `2**SEG_LOG2` words. A slow supervising processor hands the engine a starting address. From then on the engine produces every write address in that segment by itself, with no processor help, until the segment boundary is reached. The starting address can be a segment origin or any word inside a segment, so a recording can either begin fresh or append to earlier data.

Two address slots hide the processor's polling latency. The active slot holds the address currently being written. A shadow slot holds the next segment, loaded ahead of time. When the active segment fills, the shadow moves into the active slot with no idle cycle. A load-request flag, which software polls, stays high for as long as the shadow slot is empty. If a segment ends with no successor loaded, the input stalls and a sticky overrun flag records the gap. Before it is stored, every word is protected by a single-error-correcting, double-error-detecting Hamming check field, which occupies extra memory width.

Top module: `seg_rec_engine`

## Requirements
- R1: While in reset and just after it, these outputs read as follows: `in_ready`=0, `mem_we`=0, `load_req`=1, `overrun`=0, `busy`=0, `seg_count`=0.
- R2: Each stored word is `{chk[6:0], data[31:0]}`. Number the code positions from 1. Data bit j goes to the j-th position that is not a power of two (3, 5, 6, 7, 9, ...). `chk[i]` for i<6 is the XOR of the data bits whose position has bit i set. `chk[6]` is the XOR of all 32 data bits and `chk[5:0]`.
- R3: A word accepted on the input (`in_valid` and `in_ready` at a clock edge) is written in the next cycle: `mem_we`=1, the encoded word on the data lines. Words are written in the order they were accepted.
- R4: An address loaded while the active slot is empty becomes the first write address, even if it does not sit on a segment boundary.
- R5: Within a segment, each write goes to the previous address plus one. A segment ends after the word whose address has its low `SEG_LOG2` bits all ones.
- R6: An address loaded while the active slot is full goes to the shadow slot. At the end of the segment the shadow becomes active, and `in_ready` stays high with no bubble.
- R7: `load_req` is high exactly when the shadow slot is empty. A load arriving while both slots are full is ignored.
- R8: If a segment ends while the shadow slot is empty, `in_ready` falls and `overrun` is set. `overrun` stays set until a `rec_start` pulse. A later load resumes recording.
- R9: `in_ready` is high only while recording is running and the active slot is full. When `rec_stop` is sampled at an edge, a word accepted at that same edge is still written, and no word is accepted after it.
- R10: `busy` is high while recording runs or a write is pending. `seg_count` rises by one at each segment completion and is cleared by `rec_start`. `cur_addr` shows the next write address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Payload data word |
| in_ready | output | 1 | Engine can accept a word |
| seg_base | input | ADDR_W | Address to load |
| seg_load | input | 1 | Load strobe for `seg_base` |
| rec_start | input | 1 | Start recording pulse; clears overrun and count |
| rec_stop | input | 1 | Stop recording pulse |
| load_req | output | 1 | Next segment address wanted |
| overrun | output | 1 | Sticky: a segment ended without a successor |
| busy | output | 1 | Recording or write pending |
| cur_addr | output | ADDR_W | Next write address |
| seg_count | output | CNT_W | Completed segments since start |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 39 | Check bits and data |

## Verification
The bench builds the engine with `ADDR_W`=12 and `SEG_LOG2`=3, so a segment is eight words. A few dozen words are then enough to cross several segment boundaries. The runs cover:
- a seamless handover from shadow to active slot;
- an ignored third load;
- a starved boundary with its overrun;
- resumption from an address in the middle of a segment;
- a stop that coincides with an accepted word.

Data patterns include all-zero, all-one, walking-one and mixed values, so that every check bit toggles.

// File: rtl/seg_rec_pkg.sv
package seg_rec_pkg;

  localparam int DATA_W = 32;

  // smallest r with 2**r >= dw + r + 1
  function automatic int ham_bits(input int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  localparam int HAM_W  = ham_bits(DATA_W);
  localparam int CHK_W  = HAM_W + 1;
  localparam int WORD_W = DATA_W + CHK_W;

  // code position (1-based) of data bit j: the j-th non power of two from 3
  function automatic int data_pos(input int j);
    int k;
    k = 0;
    for (int p = 3; p < 4 * DATA_W + 8; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (k == j) return p;
        k++;
      end
    end
    return 0;
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import seg_rec_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int HW = ham_bits(DW)
) (
  input  logic [DW-1:0] data_i,
  output logic [HW:0]   chk_o
);

  logic [HW-1:0] ham;

  always_comb begin
    ham = '0;
    for (int j = 0; j < DW; j++) begin
      for (int i = 0; i < HW; i++) begin
        if (((data_pos(j) >> i) & 1) == 1) ham[i] = ham[i] ^ data_i[j];
      end
    end
  end

  assign chk_o = {(^data_i) ^ (^ham), ham};

endmodule

// File: rtl/seg_slot_ctrl.sv
module seg_slot_ctrl #(
  parameter int AW       = 24,
  parameter int SEG_LOG2 = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  output logic          act_vld_o,
  output logic [AW-1:0] act_addr_o,
  output logic          shd_vld_o,
  output logic          seg_end_o,
  output logic          starve_o
);

  localparam logic [SEG_LOG2-1:0] SEG_LAST = '1;

  logic          act_vld_q, act_vld_d;
  logic [AW-1:0] act_addr_q, act_addr_d;
  logic          shd_vld_q, shd_vld_d;
  logic [AW-1:0] shd_addr_q, shd_addr_d;
  logic          act_en, shd_en;
  logic          seg_end;
  logic          a_vld_mid, s_vld_mid;

  assign seg_end = accept_i && (act_addr_q[SEG_LOG2-1:0] == SEG_LAST);

  // next state: first the effect of the accepted word, then the load
  always_comb begin
    act_vld_d  = act_vld_q;
    act_addr_d = act_addr_q;
    shd_vld_d  = shd_vld_q;
    shd_addr_d = shd_addr_q;
    act_en     = 1'b0;
    shd_en     = 1'b0;

    if (seg_end) begin
      act_vld_d  = shd_vld_q;
      act_addr_d = shd_addr_q;
      shd_vld_d  = 1'b0;
      act_en     = 1'b1;
      shd_en     = 1'b1;
    end else if (accept_i) begin
      act_addr_d = act_addr_q + AW'(1);
      act_en     = 1'b1;
    end

    a_vld_mid = act_vld_d;
    s_vld_mid = shd_vld_d;

    if (load_i) begin
      if (!a_vld_mid) begin
        act_vld_d  = 1'b1;
        act_addr_d = load_addr_i;
        act_en     = 1'b1;
      end else if (!s_vld_mid) begin
        shd_vld_d  = 1'b1;
        shd_addr_d = load_addr_i;
        shd_en     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_vld_q  <= 1'b0;
      act_addr_q <= '0;
    end else if (act_en) begin
      act_vld_q  <= act_vld_d;
      act_addr_q <= act_addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_vld_q  <= 1'b0;
      shd_addr_q <= '0;
    end else if (shd_en) begin
      shd_vld_q  <= shd_vld_d;
      shd_addr_q <= shd_addr_d;
    end
  end

  assign act_vld_o  = act_vld_q;
  assign act_addr_o = act_addr_q;
  assign shd_vld_o  = shd_vld_q;
  assign seg_end_o  = seg_end;
  assign starve_o   = seg_end && !shd_vld_q;

endmodule

// File: rtl/mem_wr_stage.sv
module mem_wr_stage #(
  parameter int AW = 24,
  parameter int WW = 39
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [WW-1:0] wr_word_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [WW-1:0] mem_wdata_o
);

  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [WW-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b0;
    else        we_q <= wr_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      word_q <= '0;
    end else if (wr_en_i) begin
      addr_q <= wr_addr_i;
      word_q <= wr_word_i;
    end
  end

  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = word_q;

endmodule

// File: rtl/seg_rec_engine.sv
module seg_rec_engine
  import seg_rec_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int SEG_LOG2 = 12,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic              seg_load,
  input  logic              rec_start,
  input  logic              rec_stop,
  output logic              load_req,
  output logic              overrun,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  seg_count,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic              run_q, run_d;
  logic              ovr_q, ovr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;
  logic              act_vld, shd_vld, seg_end, starve;
  logic [ADDR_W-1:0] act_addr;
  logic              accept;
  logic [CHK_W-1:0]  chk;

  assign in_ready = run_q && act_vld;
  assign accept   = in_valid && in_ready;

  seg_slot_ctrl #(.AW(ADDR_W), .SEG_LOG2(SEG_LOG2)) u_slots (
    .clk        (clk),
    .rst_n      (rst_ni),
    .accept_i   (accept),
    .load_i     (seg_load),
    .load_addr_i(seg_base),
    .act_vld_o  (act_vld),
    .act_addr_o (act_addr),
    .shd_vld_o  (shd_vld),
    .seg_end_o  (seg_end),
    .starve_o   (starve)
  );

  secded_enc #(.DW(DATA_W), .HW(HAM_W)) u_enc (
    .data_i(in_data),
    .chk_o (chk)
  );

  mem_wr_stage #(.AW(ADDR_W), .WW(WORD_W)) u_wr (
    .clk        (clk),
    .rst_n      (rst_ni),
    .wr_en_i    (accept),
    .wr_addr_i  (act_addr),
    .wr_word_i  ({chk, in_data}),
    .mem_we_o   (mem_we),
    .mem_addr_o (mem_addr),
    .mem_wdata_o(mem_wdata)
  );

  // control next state
  always_comb begin
    run_d = run_q;
    if (rec_stop)       run_d = 1'b0;
    else if (rec_start) run_d = 1'b1;

    ovr_d = ovr_q;
    if (rec_start)   ovr_d = 1'b0;
    else if (starve) ovr_d = 1'b1;

    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (rec_start) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (seg_end) begin
      cnt_d  = cnt_q + CNT_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      run_q <= run_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign load_req  = !shd_vld;
  assign overrun   = ovr_q;
  assign busy      = run_q || mem_we;
  assign cur_addr  = act_addr;
  assign seg_count = cnt_q;

endmodule

// File: rtl/seg_rec_engine_chk.sv
module seg_rec_engine_chk #(
  parameter int ADDR_W   = 24,
  parameter int SEG_LOG2 = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              seg_load,
  input logic              rec_start,
  input logic              load_req,
  input logic              overrun,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);

  localparam logic [SEG_LOG2-1:0] LAST = '1;

  assert_wr_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> mem_we);

  assert_wr_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(in_valid && in_ready));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && ($past(mem_addr[SEG_LOG2-1:0]) != LAST))
      |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  assert_ready_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !rec_start) |=> overrun);

  assert_req_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_req) |-> $past(seg_load));

endmodule

bind seg_rec_engine seg_rec_engine_chk #(.ADDR_W(ADDR_W), .SEG_LOG2(SEG_LOG2)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .seg_load (seg_load),
  .rec_start(rec_start),
  .load_req (load_req),
  .overrun  (overrun),
  .busy     (busy),
  .mem_we   (mem_we),
  .mem_addr (mem_addr)
);

// File: tb/seg_rec_engine_tb_top.sv
`timescale 1ns/1ps
module seg_rec_engine_tb_top;

  localparam int AW  = 12;
  localparam int SL  = 3;
  localparam int CW  = 16;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [31:0]   in_data;
  logic          in_ready;
  logic [AW-1:0] seg_base;
  logic          seg_load;
  logic          rec_start;
  logic          rec_stop;
  logic          load_req;
  logic          overrun;
  logic          busy;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] seg_count;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [38:0]   mem_wdata;

  seg_rec_engine #(.ADDR_W(AW), .SEG_LOG2(SL), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .seg_base(seg_base), .seg_load(seg_load),
    .rec_start(rec_start), .rec_stop(rec_stop), .load_req(load_req),
    .overrun(overrun), .busy(busy), .cur_addr(cur_addr),
    .seg_count(seg_count), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [38:0]   w;
  } exp_t;
  exp_t exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // R2 reference: build the codeword by position, then fold parities
  function automatic logic [38:0] encode(input logic [31:0] d);
    logic [38:0] cw;
    logic [5:0]  h;
    int          j;
    cw = '0;
    j  = 0;
    for (int p = 1; p <= 38; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[j];
        j++;
      end
    end
    for (int i = 0; i < 6; i++) begin
      h[i] = 1'b0;
      for (int p = 1; p <= 38; p++) if (((p >> i) & 1) == 1) h[i] ^= cw[p];
    end
    return {(^d) ^ (^h), h, d};
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected write addr", 64'(mem_addr), 64'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(mem_addr == e.a, "R3", "write address", 64'(mem_addr), 64'(e.a));
        check(mem_wdata == e.w, "R2", "write word", 64'(mem_wdata), 64'(e.w));
      end
    end
  end

  task automatic send(input logic [31:0] d, input logic [AW-1:0] a,
                      output bit waited);
    exp_t e;
    waited   = 0;
    in_valid = 1'b1;
    in_data  = d;
    #1;
    while (!in_ready) begin
      waited = 1;
      @(negedge clk);
      #1;
    end
    e.a = a;
    e.w = encode(d);
    exp_q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic load(input logic [AW-1:0] a);
    seg_base = a;
    seg_load = 1'b1;
    @(negedge clk);
    seg_load = 1'b0;
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      report();
    end
  end

  initial begin
    bit w;
    bit any_wait;
    rst_n = 0; in_valid = 0; in_data = '0; seg_base = '0;
    seg_load = 0; rec_start = 0; rec_stop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(in_ready == 0, "R1", "in_ready", 64'(in_ready), 0);
    check(mem_we == 0, "R1", "mem_we", 64'(mem_we), 0);
    check(load_req == 1, "R1", "load_req", 64'(load_req), 1);
    check(overrun == 0, "R1", "overrun", 64'(overrun), 0);
    check(busy == 0, "R1", "busy", 64'(busy), 0);
    check(seg_count == 0, "R1", "seg_count", 64'(seg_count), 0);

    // R4/R6/R7: active, shadow, then an ignored third load
    load(12'h010);
    check(cur_addr == 12'h010, "R4", "cur_addr after load", 64'(cur_addr), 64'h010);
    check(load_req == 1, "R7", "req with shadow empty", 64'(load_req), 1);
    load(12'h040);
    check(load_req == 0, "R7", "req with shadow full", 64'(load_req), 0);
    load(12'h080);
    check(in_ready == 0, "R9", "ready before start", 64'(in_ready), 0);
    rec_start = 1;
    @(negedge clk);
    rec_start = 0;
    check(in_ready == 1, "R9", "ready after start", 64'(in_ready), 1);

    any_wait = 0;
    for (int i = 0; i < 12; i++) begin
      logic [31:0] d;
      d = (i == 0) ? 32'h0 : (i == 1) ? 32'hFFFF_FFFF :
          (i < 8) ? (32'h1 << (i * 5)) : 32'(i) * 32'h9E37_79B9;
      send(d, (i < 8) ? AW'(12'h010 + i) : AW'(12'h040 + i - 8), w);
      any_wait |= w;
    end
    check(any_wait == 0, "R6", "bubble at segment switch", 64'(any_wait), 0);
    check(load_req == 1, "R7", "req after shadow used", 64'(load_req), 1);
    check(seg_count == 1, "R10", "seg_count", 64'(seg_count), 1);
    check(cur_addr == 12'h044, "R10", "cur_addr", 64'(cur_addr), 64'h044);
    check(overrun == 0, "R8", "no overrun yet", 64'(overrun), 0);

    // R8: finish segment with no successor (0x080 load was dropped, R7)
    for (int i = 0; i < 4; i++) send(32'hA5A5_0000 | 32'(i), AW'(12'h044 + i), w);
    check(in_ready == 0, "R8", "ready after starve", 64'(in_ready), 0);
    check(overrun == 1, "R8", "overrun set", 64'(overrun), 1);
    check(seg_count == 2, "R10", "seg_count", 64'(seg_count), 2);
    check(load_req == 1, "R7", "req while empty", 64'(load_req), 1);
    repeat (2) @(negedge clk);
    check(overrun == 1, "R8", "overrun sticky", 64'(overrun), 1);

    // R4: resume from an address inside a segment
    load(12'h105);
    check(in_ready == 1, "R8", "ready after reload", 64'(in_ready), 1);
    check(cur_addr == 12'h105, "R4", "append addr", 64'(cur_addr), 64'h105);
    load(12'h200);
    send(32'h1234_5678, 12'h105, w);
    send(32'h8000_0001, 12'h106, w);
    send(32'h0F0F_F0F0, 12'h107, w);
    send(32'hDEAD_BEEF, 12'h200, w);
    send(32'h7FFF_FFFE, 12'h201, w);
    check(overrun == 1, "R8", "still sticky", 64'(overrun), 1);

    // R9: stop coinciding with an accepted word
    in_valid = 1; in_data = 32'hC0DE_0001; rec_stop = 1;
    #1;
    check(in_ready == 1, "R9", "ready at stop edge", 64'(in_ready), 1);
    begin
      exp_t e;
      e.a = 12'h202;
      e.w = encode(32'hC0DE_0001);
      exp_q.push_back(e);
    end
    @(negedge clk);
    rec_stop = 0;
    check(in_ready == 0, "R9", "ready after stop", 64'(in_ready), 0);
    check(busy == 1, "R10", "busy with write pending", 64'(busy), 1);
    @(negedge clk);
    check(busy == 0, "R10", "idle after write", 64'(busy), 0);
    repeat (3) @(negedge clk);
    in_valid = 0;

    // R10: restart clears count and overrun, continues at next address
    rec_start = 1;
    @(negedge clk);
    rec_start = 0;
    check(overrun == 0, "R8", "cleared by start", 64'(overrun), 0);
    check(seg_count == 0, "R10", "count cleared", 64'(seg_count), 0);
    check(cur_addr == 12'h203, "R10", "cur_addr after restart", 64'(cur_addr), 64'h203);
    send(32'h5555_AAAA, 12'h203, w);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3", "writes outstanding", 64'(exp_q.size()), 0);
    done = 1;
    report();
  end

endmodule